// File: doc/BRIEF.md
# Time-Multiplexed Dual-Channel SAR Conversion Controller

This block is the digital sequencer for one shared 4-bit successive-approximation ADC in a current-mode power converter. Both the output voltage and the inductor current are sampled when each switching period starts. The voltage is converted in the first half of the period and the held current sample in the second half. The analog capacitor array, comparator, sample-and-hold and on-demand oscillator sit outside the block.

A rising edge of the switching clock starts a voltage conversion. A falling edge starts a current conversion. For each conversion the block does four things: it selects the reference window for the capacitor array, it raises the oscillator enable, it walks the trial code from the most significant bit down on falling edges of the conversion clock, and it then drops the enable. Dropping the enable also resets the oscillator. The finished code goes to the voltage loop or the current loop, each with its own one-cycle strobe. A start edge that arrives while a conversion is still in progress is reported and discarded.

All inputs are synchronous to the system clock `clk`. The switching clock and the conversion clock are sampled as levels, and their edges are detected inside the block.

Top module: `tm_sar_ctrl`

## Requirements
- R1: `sample_o` is high for exactly one `clk` cycle after each rising edge of `sw_clk_i`, and never follows a falling edge.
- R2: On a rising edge of `sw_clk_i` with no conversion running, the next cycle shows `osc_en_o` high, `ref_sel_o` = 0 (the voltage window) and `trial_o` = 4'b1000.
- R3: On a falling edge of `sw_clk_i` with no conversion running, the next cycle shows `osc_en_o` high, `ref_sel_o` = 1 (the current window) and `trial_o` = 4'b1000. `ref_sel_o` stays constant for as long as `osc_en_o` is high.
- R4: Bits are decided from the MSB down. When `cmp_i` = 1 the trial is too high and the bit under test is cleared. Otherwise that bit is kept, and the next lower bit is set for the following trial. With a comparator that reports trial > level, the result equals the level (0..15).
- R5: Approximation steps advance only on falling edges of `osc_clk_i`. Each conversion consumes exactly five such edges while `osc_enable` is high. `osc_en_o` drops on the fifth edge, and one more `clk` cycle passes before a new start is accepted.
- R6: A voltage result is published on `verr_o` with a one-cycle `verr_vld_o`, and a current result on `isamp_o` with a one-cycle `isamp_vld_o`. The two strobes are never high together, and each result register holds its value until that channel's next result.
- R7: When each half-period is long enough for a conversion, the voltage strobe arrives while `sw_clk_i` is still high, and the current strobe arrives before the next rising edge.
- R8: A start edge that arrives while a conversion or its reset cycle is in progress produces a one-cycle `overrun_o` pulse. It starts no conversion and gives no result for its channel, and the conversion already running finishes with the correct code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_clk_i | input | 1 | Switching-clock level |
| osc_clk_i | input | 1 | Output of the on-demand conversion oscillator |
| cmp_i | input | 1 | Comparator bit, 1 = trial code above sample |
| osc_en_o | output | 1 | Oscillator enable, high during a conversion |
| ref_sel_o | output | 1 | Reference window select, 0 voltage, 1 current |
| trial_o | output | 4 | Capacitor-switch trial code |
| sample_o | output | 1 | Sample strobe for both sample-and-holds |
| verr_o | output | 4 | Last voltage-channel code |
| verr_vld_o | output | 1 | One-cycle strobe for new `verr_o` |
| isamp_o | output | 4 | Last current-channel code |
| isamp_vld_o | output | 1 | One-cycle strobe for new `isamp_o` |
| overrun_o | output | 1 | One-cycle pulse, start edge discarded |

## Verification
Pairs of levels at opposite extremes (0 with 15, then 15 with 0) show whether a result lands on the wrong channel. Mid-range pairs and a sweep of every code exercise each keep-or-clear decision of the bit walk. One pattern changes the current level after the period has started, which shows whether the held sample is converted rather than the live level. A shortened high phase puts the falling edge inside a running voltage conversion. This separates a discarded start from one that corrupts the voltage result, and a following normal period shows that the block recovers.

// File: rtl/tm_sar_pkg.sv
package tm_sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_RST  = 2'd2
  } sar_state_e;

  localparam logic CH_VOLT = 1'b0;
  localparam logic CH_CURR = 1'b1;
endpackage

// File: rtl/sar_edge.sv
module sar_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse_o = lvl_i & ~lvl_q;
    end else begin : g_fall
      assign pulse_o = ~lvl_i & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/sar_core.sv
module sar_core
  import tm_sar_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rise_i,
  input  logic             sw_fall_i,
  input  logic             osc_fall_i,
  input  logic             cmp_i,
  output logic             osc_en_o,
  output logic             chan_o,
  output logic [NBITS-1:0] trial_o,
  output logic             done_o,
  output logic             sample_o,
  output logic             overrun_o
);
  localparam int STEP_W = $clog2(NBITS + 1);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NBITS);

  sar_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              start_w;
  logic              busy_w;

  assign start_w = sw_rise_i | sw_fall_i;
  assign busy_w  = (state_q != ST_IDLE);

  // One approximation step: decide bit (NBITS-1-s), set the next lower one.
  function automatic logic [NBITS-1:0] sar_next(input logic [NBITS-1:0] t,
                                                input logic [STEP_W-1:0] s,
                                                input logic c);
    logic [NBITS-1:0] n;
    n = t;
    for (int k = 0; k < NBITS; k++) begin
      if (k == NBITS - 1 - int'(s) && c) n[k] = 1'b0;
      if (k == NBITS - 2 - int'(s))      n[k] = 1'b1;
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      osc_en_o  <= 1'b0;
      chan_o    <= CH_VOLT;
      trial_o   <= '0;
      done_o    <= 1'b0;
      sample_o  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      sample_o  <= sw_rise_i;
      overrun_o <= start_w & busy_w;
      case (state_q)
        ST_IDLE: begin
          if (start_w) begin
            state_q  <= ST_CONV;
            chan_o   <= sw_fall_i ? CH_CURR : CH_VOLT;
            trial_o  <= MSB_ONE;
            step_q   <= '0;
            osc_en_o <= 1'b1;
          end
        end
        ST_CONV: begin
          if (osc_fall_i) begin
            if (step_q == LAST_STEP) begin
              state_q  <= ST_RST;
              osc_en_o <= 1'b0;
              done_o   <= 1'b1;
            end else begin
              trial_o <= sar_next(trial_o, step_q, cmp_i);
              step_q  <= step_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RISE_STARTS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rise_i && !busy_w) |=> (osc_en_o && chan_o == CH_VOLT && trial_o == MSB_ONE)); // R2
  AST_FALL_STARTS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fall_i && !busy_w) |=> (osc_en_o && chan_o == CH_CURR && trial_o == MSB_ONE)); // R3
  AST_REF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_o && $past(osc_en_o)) |-> $stable(chan_o)); // R3
  AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!osc_en_o && $past(osc_en_o))); // R5
  AST_OVR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(busy_w)); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && busy_w) |=> $stable(chan_o)); // R8
endmodule

// File: rtl/sar_router.sv
module sar_router #(
  parameter int NBITS = 4,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             chan_i,
  input  logic [NBITS-1:0] code_i,
  output logic [NBITS-1:0] res_o [NCH],
  output logic             vld_o [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_w;
    assign hit_w = done_i && (int'(chan_i) == g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_o[g] <= '0;
        vld_o[g] <= 1'b0;
      end else begin
        vld_o[g] <= hit_w;
        if (hit_w) res_o[g] <= code_i;
      end
    end
  end

  AST_VLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_o[0] && vld_o[1])); // R6
endmodule

// File: rtl/tm_sar_ctrl.sv
module tm_sar_ctrl #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clk_i,
  input  logic             osc_clk_i,
  input  logic             cmp_i,
  output logic             osc_en_o,
  output logic             ref_sel_o,
  output logic [NBITS-1:0] trial_o,
  output logic             sample_o,
  output logic [NBITS-1:0] verr_o,
  output logic             verr_vld_o,
  output logic [NBITS-1:0] isamp_o,
  output logic             isamp_vld_o,
  output logic             overrun_o
);
  localparam int NCH = 2;

  logic             sw_rise_w;
  logic             sw_fall_w;
  logic             osc_fall_w;
  logic             done_w;
  logic [NBITS-1:0] res_w [NCH];
  logic             vld_w [NCH];

  sar_edge #(.RISE(1'b1)) u_sw_rise (
    .clk(clk), .rst_n(rst_n), .lvl_i(sw_clk_i), .pulse_o(sw_rise_w));
  sar_edge #(.RISE(1'b0)) u_sw_fall (
    .clk(clk), .rst_n(rst_n), .lvl_i(sw_clk_i), .pulse_o(sw_fall_w));
  sar_edge #(.RISE(1'b0)) u_osc_fall (
    .clk(clk), .rst_n(rst_n), .lvl_i(osc_clk_i), .pulse_o(osc_fall_w));

  sar_core #(.NBITS(NBITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rise_i (sw_rise_w),
    .sw_fall_i (sw_fall_w),
    .osc_fall_i(osc_fall_w),
    .cmp_i     (cmp_i),
    .osc_en_o  (osc_en_o),
    .chan_o    (ref_sel_o),
    .trial_o   (trial_o),
    .done_o    (done_w),
    .sample_o  (sample_o),
    .overrun_o (overrun_o)
  );

  sar_router #(.NBITS(NBITS), .NCH(NCH)) u_router (
    .clk   (clk),
    .rst_n (rst_n),
    .done_i(done_w),
    .chan_i(ref_sel_o),
    .code_i(trial_o),
    .res_o (res_w),
    .vld_o (vld_w)
  );

  assign verr_o      = res_w[0];
  assign verr_vld_o  = vld_w[0];
  assign isamp_o     = res_w[1];
  assign isamp_vld_o = vld_w[1];

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> $past(sw_rise_w)); // R1
endmodule

// File: tb/tm_sar_ctrl_tb_top.sv
module tm_sar_ctrl_tb_top;
  localparam int HALF = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_clk_i = 1'b0;
  logic       osc_clk_i = 1'b0;
  logic       cmp_i;
  logic       osc_en_o, ref_sel_o, sample_o;
  logic [3:0] trial_o, verr_o, isamp_o;
  logic       verr_vld_o, isamp_vld_o, overrun_o;

  int checks = 0;
  int errors = 0;

  int  v_lvl = 0, i_lvl = 0, v_hold = 0, i_hold = 0;
  int  v_seen, i_seen, smp_seen, ovr_seen;
  int  got_v, got_i;
  bit  v_in_high, i_late, smp_on_low;
  int  osc_div = 0, conv_falls = 0;
  bit  en_prev = 1'b0, en_chan = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  tm_sar_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_clk_i(sw_clk_i), .osc_clk_i(osc_clk_i),
    .cmp_i(cmp_i), .osc_en_o(osc_en_o), .ref_sel_o(ref_sel_o),
    .trial_o(trial_o), .sample_o(sample_o), .verr_o(verr_o),
    .verr_vld_o(verr_vld_o), .isamp_o(isamp_o), .isamp_vld_o(isamp_vld_o),
    .overrun_o(overrun_o));

  // Comparator model: 1 when the trial code exceeds the held sample.
  assign cmp_i = (int'(trial_o) > (ref_sel_o ? i_hold : v_hold));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // On-demand oscillator model and monitor, both on the inactive edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!osc_en_o) begin
        osc_clk_i = 1'b0;
        osc_div = 0;
      end else begin
        osc_div++;
        if (osc_div == 3) begin
          osc_div = 0;
          if (osc_clk_i) conv_falls++;
          osc_clk_i = ~osc_clk_i;
        end
      end
      if (sample_o) begin
        smp_seen++;
        if (!sw_clk_i) smp_on_low = 1'b1;
        v_hold = v_lvl;
        i_hold = i_lvl;
      end
      if (osc_en_o && !en_prev) begin
        conv_falls = 0;
        en_chan = ref_sel_o;
        chk(trial_o == 4'b1000, "R4 first trial MSB", trial_o, 8);
        chk(ref_sel_o == ~sw_clk_i, "R2/R3 window select", ref_sel_o, ~sw_clk_i);
      end
      if (osc_en_o && en_prev && ref_sel_o != en_chan)
        chk(1'b0, "R3 window stable", ref_sel_o, en_chan);
      if (!osc_en_o && en_prev)
        chk(conv_falls == 5, "R5 five conversion edges", conv_falls, 5);
      if (verr_vld_o) begin v_seen++; got_v = verr_o; v_in_high = sw_clk_i; end
      if (isamp_vld_o) begin i_seen++; got_i = isamp_o; i_late = sw_clk_i; end
      if (verr_vld_o && isamp_vld_o) chk(1'b0, "R6 exclusive strobes", 1, 0);
      if (overrun_o) ovr_seen++;
      en_prev = osc_en_o;
    end
  end

  task automatic clear_mon();
    v_seen = 0; i_seen = 0; smp_seen = 0; ovr_seen = 0;
    v_in_high = 1'b0; i_late = 1'b0; smp_on_low = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!osc_en_o && !verr_vld_o && !isamp_vld_o && !overrun_o && !sample_o,
        "R5 reset idle", {osc_en_o, verr_vld_o, isamp_vld_o, overrun_o, sample_o}, 0);
    chk(verr_o == 0 && isamp_o == 0, "R6 reset results", {verr_o, isamp_o}, 0);
  endtask

  // One normal period; optionally change the current level after sampling.
  task automatic t_period(input int v, input int i, input int i_after);
    v_lvl = v; i_lvl = i;
    clear_mon();
    @(negedge clk); sw_clk_i = 1'b1;
    repeat (5) @(negedge clk);
    i_lvl = i_after;
    repeat (HALF - 5) @(negedge clk);
    sw_clk_i = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(smp_seen == 1 && !smp_on_low, "R1 one sample per rise", smp_seen, 1);
    chk(v_seen == 1 && got_v == v, "R4 R6 voltage code", got_v, v);
    chk(i_seen == 1 && got_i == i, "R4 R6 current code", got_i, i);
    chk(v_in_high, "R7 voltage before fall", v_in_high, 1);
    chk(!i_late, "R7 current before next rise", i_late, 0);
    chk(ovr_seen == 0, "R8 no overrun", ovr_seen, 0);
  endtask

  // Falling edge arrives during the voltage conversion.
  task automatic t_overrun(input int v, input int i, input int prev_i);
    v_lvl = v; i_lvl = i;
    clear_mon();
    @(negedge clk); sw_clk_i = 1'b1;
    repeat (8) @(negedge clk);
    sw_clk_i = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    chk(ovr_seen == 1, "R8 overrun flagged", ovr_seen, 1);
    chk(i_seen == 0, "R8 no current result", i_seen, 0);
    chk(isamp_o == 4'(prev_i), "R6 R8 current holds", isamp_o, prev_i);
    chk(v_seen == 1 && got_v == v, "R8 voltage intact", got_v, v);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period(0, 15, 15);
    t_period(15, 0, 0);
    t_period(10, 5, 5);
    t_period(6, 9, 9);
    t_period(12, 3, 14);
    for (int k = 0; k < 16; k++) t_period(k, 15 - k, 15 - k);
    t_overrun(7, 3, 0);
    t_period(9, 11, 11);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule